// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block is a clocked model of the command side of a byte-wide flash memory. It samples chip select, write enable and output enable on every clock and treats each interval during which chip select and write enable are both low as one bus write. A finished write goes to a sequence decoder. The decoder accepts only exact unlock patterns before it acts on a command. The commands are identifier readout, byte program, chip erase and return to read mode. The storage behind it is a small register array whose bytes start at FFH. A program can only clear bits. An erase sets every byte back to FFH.

The decoder is a state machine with these states: ST_READ (normal reads), ST_UNLOCK_A and ST_UNLOCK_B (first and second unlock write seen), ST_PROG_ARM (program command taken, waiting for the address/data write), ST_ERASE_ARM (erase setup taken), ST_ERASE_UNLOCK_A and ST_ERASE_UNLOCK_B (the second unlock pair during erase), ST_ID_MODE (identifier readout), ST_PROG_BUSY and ST_ERASE_BUSY (embedded operation running). The transitions are:

- ST_READ goes to ST_UNLOCK_A on AAH at 5555H.
- ST_UNLOCK_A goes to ST_UNLOCK_B on 55H at 2AAAH.
- ST_UNLOCK_B goes to ST_ID_MODE, ST_PROG_ARM or ST_ERASE_ARM on 90H, A0H or 80H at 5555H.
- ST_PROG_ARM goes to ST_PROG_BUSY on any write.
- ST_ERASE_ARM goes to ST_ERASE_UNLOCK_A on AAH at 5555H.
- ST_ERASE_UNLOCK_A goes to ST_ERASE_UNLOCK_B on 55H at 2AAAH.
- ST_ERASE_UNLOCK_B goes to ST_ERASE_BUSY on 10H at 5555H.
- Both busy states go to ST_READ when their duration counter expires.
- ST_ID_MODE and every unexpected write go to ST_READ.

While an operation runs, the controller reports its progress on data bit 7, which system software polls.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in read mode and every array byte reads FFH.
- R2: In read mode, with cs_n low, oe_n low and we_n high, dout_en is 1 and dout is the array byte at index addr[IDX_W-1:0]. When that condition does not hold, dout_en is 0 and dout is 00H.
- R3: Three writes put the controller in identifier mode: AAH at 5555H, 55H at 2AAAH, then 90H at 5555H. In this mode a read returns a code selected by addr[1:0]: offset 0 gives 01H (manufacturer), offset 1 gives 20H (device), and offsets 2 and 3 give 80H (no sector protected).
- R4: Every byte read in identifier mode has an odd number of 1 bits, with bit 7 acting as the parity bit over bits 6:0.
- R5: Identifier mode lasts through any number of reads. Any write, such as F0H at any address, returns the controller to read mode.
- R6: A byte program takes four writes: AAH at 5555H, 55H at 2AAAH, A0H at 5555H, then the data at the target address. During the next PROG_CYCLES clocks, every read returns the complement of the written bit 7 in bit 7 and zeros in bits 6:0.
- R7: A finished program stores the old byte ANDed with the written byte. A bit that is already 0 stays 0.
- R8: A chip erase takes six writes: AAH at 5555H, 55H at 2AAAH, 80H at 5555H, AAH at 5555H, 55H at 2AAAH, then 10H at 5555H. During the next ERASE_CYCLES clocks, reads return 00H. After that every byte reads FFH and the controller is in read mode.
- R9: Writes made while a program or erase runs have no effect, whatever their address or data.
- R10: A write that does not match the next expected step of a sequence, including F0H, aborts the sequence and leaves the controller in read mode. No program or erase takes place.
- R11: A bus write begins on the first clock at which cs_n and we_n are both low, and the address is taken at that clock. The data is the value on din at the last clock before either signal goes high. The command is acted on after the write ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status |
| dout_en | output | 1 | High when the controller drives read data |

## Verification
The assertions check on every clock the properties that hold cycle by cycle:

- the write strobe follows the end of a write cycle and lasts one clock;
- a busy state cannot end before its counter runs out, however many writes arrive;
- a broken unlock falls back to read mode;
- a program never raises a bit;
- an erase leaves FFH behind;
- every identifier byte has odd parity.

Only the bench scenarios can show the rest:

- the full command sequences and the exact code values at each identifier offset;
- the length of the status window seen through polling;
- the stored result of layered programs across every address;
- that aborted or late writes leave the array unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLOCK_A,
        ST_UNLOCK_B,
        ST_PROG_ARM,
        ST_ERASE_ARM,
        ST_ERASE_UNLOCK_A,
        ST_ERASE_UNLOCK_B,
        ST_ID_MODE,
        ST_PROG_BUSY,
        ST_ERASE_BUSY
    } cmd_state_t;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A      = 8'hAA;
    localparam logic [7:0]  KEY_B      = 8'h55;
    localparam logic [7:0]  OP_ID      = 8'h90;
    localparam logic [7:0]  OP_PROG    = 8'hA0;
    localparam logic [7:0]  OP_ERASE   = 8'h80;
    localparam logic [7:0]  OP_CHIP    = 8'h10;

    localparam logic [6:0]  ID_MAKER   = 7'h01;
    localparam logic [6:0]  ID_PART    = 7'h20;
    localparam logic [6:0]  ID_PROTECT = 7'h00;

endpackage

// File: rtl/fcs_bus_sampler.sv
module fcs_bus_sampler #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    logic wr_act;
    logic wr_act_q;

    assign wr_act = ~cs_n & ~we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_act_q <= wr_act;
            wr_stb   <= wr_act_q & ~wr_act;
            if (wr_act && !wr_act_q) begin
                wr_addr <= addr;
            end
            if (wr_act) begin
                wr_data <= din;
            end
        end
    end

    // R11: a strobe means a write was active two clocks back and ended one clock back
    a_r11_stb_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(~cs_n & ~we_n, 2) && !$past(~cs_n & ~we_n, 1)));

    a_r11_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int IDX_W        = 4,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output cmd_state_t        state,
    output logic              prog_en,
    output logic              erase_en,
    output logic [IDX_W-1:0]  pgm_idx,
    output logic [7:0]        pgm_data
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

    cmd_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             hit_a;
    logic             hit_b;
    logic             at_cmd;
    logic             busy;

    assign hit_a  = (wr_addr == ADR_A) && (wr_data == KEY_A);
    assign hit_b  = (wr_addr == ADR_B) && (wr_data == KEY_B);
    assign at_cmd = (wr_addr == ADR_A);
    assign busy   = (state == ST_PROG_BUSY) || (state == ST_ERASE_BUSY);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_READ:           if (wr_stb) nxt = hit_a ? ST_UNLOCK_A : ST_READ;
            ST_UNLOCK_A:       if (wr_stb) nxt = hit_b ? ST_UNLOCK_B : ST_READ;
            ST_UNLOCK_B: begin
                if (wr_stb) begin
                    if (at_cmd && wr_data == OP_ID)         nxt = ST_ID_MODE;
                    else if (at_cmd && wr_data == OP_PROG)  nxt = ST_PROG_ARM;
                    else if (at_cmd && wr_data == OP_ERASE) nxt = ST_ERASE_ARM;
                    else                                    nxt = ST_READ;
                end
            end
            ST_PROG_ARM:       if (wr_stb) nxt = ST_PROG_BUSY;
            ST_ERASE_ARM:      if (wr_stb) nxt = hit_a ? ST_ERASE_UNLOCK_A : ST_READ;
            ST_ERASE_UNLOCK_A: if (wr_stb) nxt = hit_b ? ST_ERASE_UNLOCK_B : ST_READ;
            ST_ERASE_UNLOCK_B: begin
                if (wr_stb) nxt = (at_cmd && wr_data == OP_CHIP) ? ST_ERASE_BUSY : ST_READ;
            end
            ST_ID_MODE:        if (wr_stb) nxt = ST_READ;
            ST_PROG_BUSY:      if (cnt == '0) nxt = ST_READ;
            ST_ERASE_BUSY:     if (cnt == '0) nxt = ST_READ;
            default:           nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_READ;
            cnt      <= '0;
            pgm_idx  <= '0;
            pgm_data <= '0;
        end else begin
            state <= nxt;
            if (state == ST_PROG_ARM && wr_stb) begin
                cnt      <= CNT_W'(PROG_CYCLES - 1);
                pgm_idx  <= wr_addr[IDX_W-1:0];
                pgm_data <= wr_data;
            end else if (state == ST_ERASE_UNLOCK_B && nxt == ST_ERASE_BUSY) begin
                cnt <= CNT_W'(ERASE_CYCLES - 1);
            end else if (busy && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        prog_en  = (state == ST_PROG_BUSY)  && (cnt == '0);
        erase_en = (state == ST_ERASE_BUSY) && (cnt == '0);
    end

    // R9: a running operation is not left early, whatever writes arrive
    a_r9_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG_BUSY && cnt != '0) |=> state == ST_PROG_BUSY);

    a_r9_erase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE_BUSY && cnt != '0) |=> state == ST_ERASE_BUSY);

    // R10: a wrong second unlock write returns to read mode
    a_r10_abort_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNLOCK_A && wr_stb && !hit_b) |=> state == ST_READ);

    // R8: leaving the erase state always coincides with the array fill
    a_r8_erase_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_ERASE_BUSY) |-> $past(erase_en));

endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [7:0]       prog_data,
    input  logic             erase_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase_en) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= 8'hFF;
            end
        end else if (prog_en) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    assign rd_data = mem[rd_idx];

    // R7: a program never turns a 0 bit into a 1
    a_r7_no_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem[$past(prog_idx)] & ~$past(mem[prog_idx])) == 8'h00));

    // R8: after the fill any byte reads erased
    a_r8_erased: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[rd_idx] == 8'hFF));

    a_r8_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_en, erase_en}));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 15,
    parameter int IDX_W        = 4,
    parameter int PROG_CYCLES  = 16,
    parameter int ERASE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    cmd_state_t        state;
    logic              prog_en;
    logic              erase_en;
    logic [IDX_W-1:0]  pgm_idx;
    logic [7:0]        pgm_data;
    logic [7:0]        arr_byte;
    logic [6:0]        id_low;
    logic [7:0]        rd_byte;

    fcs_bus_sampler #(.ADDR_W(ADDR_W)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fcs_cmd_fsm #(
        .ADDR_W       (ADDR_W),
        .IDX_W        (IDX_W),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .state    (state),
        .prog_en  (prog_en),
        .erase_en (erase_en),
        .pgm_idx  (pgm_idx),
        .pgm_data (pgm_data)
    );

    fcs_array #(.IDX_W(IDX_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_idx  (pgm_idx),
        .prog_data (pgm_data),
        .erase_en  (erase_en),
        .rd_idx    (addr[IDX_W-1:0]),
        .rd_data   (arr_byte)
    );

    always_comb begin
        unique case (addr[1:0])
            2'd0:    id_low = ID_MAKER;
            2'd1:    id_low = ID_PART;
            default: id_low = ID_PROTECT;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_PROG_BUSY:  rd_byte = {~pgm_data[7], 7'b0};
            ST_ERASE_BUSY: rd_byte = 8'h00;
            ST_ID_MODE:    rd_byte = {~^id_low, id_low};
            default:       rd_byte = arr_byte;
        endcase
        dout_en = ~cs_n & ~oe_n & we_n;
        dout    = dout_en ? rd_byte : 8'h00;
    end

    // R4: identifier bytes carry odd parity
    a_r4_id_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ID_MODE && dout_en) |-> (^dout == 1'b1));

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;

    localparam int AW = 15;
    localparam int IW = 4;
    localparam int PC = 8;
    localparam int EC = 20;
    localparam int NB = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [7:0] model [NB];

    always #2 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W(AW), .IDX_W(IW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic read_at(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        #1;
        v = dout;
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'hA0);
        bus_write(a, d);
    endtask

    // count clocks in which bit 7 differs from the final value; check status bytes
    task automatic poll(input logic [AW-1:0] a, input logic [7:0] status,
                        input logic final7, output int n);
        n = 0;
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            #1;
            if (dout[7] == final7) break;
            if (dout != status) chk(1'b0, "R6/R8 status byte", dout, status);
            n++;
        end
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    function automatic logic [7:0] id_exp(input int off);
        logic [6:0] lo;
        lo = (off == 0) ? 7'h01 : (off == 1) ? 7'h20 : 7'h00;
        return {($countones(lo) % 2) == 0, lo};
    endfunction

    task automatic prog_and_check(input int i, input logic [7:0] d, input string tag);
        logic [7:0] expv;
        logic [7:0] v;
        int n;
        expv = model[i] & d;
        prog_seq(AW'(i), d);
        if (d[7] == 1'b0 || model[i][7] == 1'b1) begin
            poll(AW'(i), {~d[7], 7'b0}, expv[7], n);
            chk(n == PC, "R6 busy window length", n, PC);
        end else begin
            repeat (PC + 2) @(negedge clk);
        end
        model[i] = expv;
        read_at(AW'(i), v);
        chk(v == expv, tag, v, expv);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1-watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        int n;
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: reset state, idle outputs, full sweep of erased array
        #1;
        chk(dout_en == 1'b0 && dout == 8'h00, "R2 idle bus quiet", dout, 0);
        for (int i = 0; i < NB; i++) begin
            read_at(AW'(i), v);
            chk(v == 8'hFF, "R1 reset byte", v, 8'hFF);
        end
        @(negedge clk);
        addr = 15'd3; cs_n = 1'b0; oe_n = 1'b1; #1;
        chk(dout_en == 1'b0 && dout == 8'h00, "R2 oe_n high no drive", dout, 0);
        cs_n = 1'b1;

        // R6 / R7: program every address with two overlapping patterns
        for (int i = 0; i < NB; i++)
            prog_and_check(i, 8'((i * 29 + 7) ^ 8'h5A), "R7 first pass");
        for (int i = 0; i < NB; i++)
            prog_and_check(i, 8'hFF ^ 8'(i << 3), "R7 second pass over zeros");

        // R3 / R4 / R5: identifier mode
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h90);
        for (int r = 0; r < 2; r++) begin
            for (int off = 0; off < 4; off++) begin
                read_at(AW'(off + 16 * r), v);
                chk(v == id_exp(off), "R3 identifier code", v, id_exp(off));
                chk(($countones(v) % 2) == 1, "R4 odd parity", $countones(v), 1);
            end
        end
        read_at(15'h0102, v);
        chk(v == 8'h80, "R5 persists across reads", v, 8'h80);
        bus_write(15'h0000, 8'hF0);
        read_at(15'd1, v);
        chk(v == model[1], "R5 F0 exits id mode", v, model[1]);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h90);
        bus_write(15'h0007, 8'h12);
        read_at(15'd0, v);
        chk(v == model[0], "R5 other write exits id mode", v, model[0]);

        // R10: broken sequences do nothing
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAB, 8'h55);
        bus_write(15'h5555, 8'hA0);
        bus_write(15'h0003, 8'h00);
        read_at(15'd3, v);
        chk(v == model[3], "R10 bad unlock address", v, model[3]);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h77);
        bus_write(15'h0004, 8'h00);
        read_at(15'd4, v);
        chk(v == model[4], "R10 unknown command", v, model[4]);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h0000, 8'hF0);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'hA0);
        bus_write(15'h0005, 8'h00);
        read_at(15'd5, v);
        chk(v == model[5], "R10 F0 mid sequence", v, model[5]);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h80);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h54);
        bus_write(15'h5555, 8'h10);
        read_at(15'd6, v);
        chk(v == model[6], "R10 broken erase", v, model[6]);

        // R11: address at start of cycle, data at end, cs_n leading
        @(negedge clk);
        addr = 15'h1234; din = 8'h00; cs_n = 1'b0;
        @(negedge clk);
        addr = 15'h5555; we_n = 1'b0;
        @(negedge clk);
        addr = 15'h0000; din = 8'hAA;
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        we_n = 1'b1;
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'hA0);
        bus_write(15'h0002, 8'h00);
        repeat (PC + 2) @(negedge clk);
        model[2] = 8'h00;
        read_at(15'd2, v);
        chk(v == 8'h00, "R11 capture timing", v, 8'h00);

        // R9: writes during a program are ignored
        prog_seq(15'd9, 8'h0F);
        bus_write(15'h0009, 8'hF0);
        bus_write(15'h5555, 8'hAA);
        repeat (PC + 2) @(negedge clk);
        model[9] = model[9] & 8'h0F;
        read_at(15'd9, v);
        chk(v == model[9], "R9 program not aborted", v, model[9]);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'hA0);
        bus_write(15'h000A, 8'h00);
        read_at(15'd10, v);
        chk(v == model[10], "R9 busy write not an unlock", v, model[10]);

        // R8: chip erase
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h80);
        bus_write(15'h5555, 8'hAA);
        bus_write(15'h2AAA, 8'h55);
        bus_write(15'h5555, 8'h10);
        poll(15'd2, 8'h00, 1'b1, n);
        chk(n == EC, "R8 erase window length", n, EC);
        for (int i = 0; i < NB; i++) begin
            model[i] = 8'hFF;
            read_at(AW'(i), v);
            chk(v == 8'hFF, "R8 erased byte", v, 8'hFF);
        end
        prog_and_check(7, 8'h3C, "R8 back in read mode");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule